// File: doc/BRIEF.md
# Recirculating Display Line Buffer

This block keeps one row of background tile words in a 20-slot ring and plays that row back on every display scanline. A falling edge on the shift strobe moves the ring forward by one slot and updates the tile word output. The block works in one of two modes. In replay mode, each step presents the word already stored in the current slot and leaves the ring contents unchanged. In fetch mode, each step reads the next word from a 240-entry background table, stores it in the current slot and presents it on the output. After each fetch the table index moves forward by one.

No scanline counter decides when a new row is fetched. Fetch mode starts only when bus acknowledge has been held for 9 phase-clock cycles with no shift strobe in that time. Any strobe restarts the wait. Fetch mode ends as soon as acknowledge drops. Interrupt acknowledge starts a new frame: it sets both the table index and the ring position to zero and clears fetch mode. The phase clock and the strobe are asynchronous pins. Both are sampled on the fast system clock, so every change of state happens on that clock. The table has a simple write port so the processor side can fill it.

Top module: `tile_line_replay`

## Requirements
- R1: After reset, `tile_word` is 0, `fetch_mode` is 0, and all ring slots hold 0.
- R2: Each 1-to-0 transition of `shift_strobe` advances the ring by exactly one slot and updates `tile_word`. A 0-to-1 transition leaves `tile_word` unchanged.
- R3: While `bus_ack` is 1, rising edges of `phase_clk` are counted, and any strobe clears the count. `fetch_mode` becomes 1 on the 9th counted phase edge, and not on the 8th.
- R4: `fetch_mode` returns to 0 within a few system clocks after `bus_ack` goes to 0.
- R5: In fetch mode, each strobe writes table[index] into the current slot and drives it on `tile_word`, and then the index increments.
- R6: In replay mode, each strobe drives the stored word of the current slot and leaves the ring contents unchanged. The same row repeats for any number of scanlines.
- R7: While `int_ack` is 1, the table index and ring position are held at 0 and `fetch_mode` is 0. Ring contents are kept.
- R8: The table index stops at 239. Fetches beyond that repeat entry 239 until the next `int_ack`.
- R9: A fetch burst of fewer than 20 strobes moves the index and the ring position by the burst length. Later replay continues from the slot where the burst ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the phase clock and the strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_clk | input | 1 | Bus phase clock. Its rising edges are counted for the fetch hold-off |
| shift_strobe | input | 1 | Shift strobe. A falling edge advances the ring |
| bus_ack | input | 1 | Bus acknowledge, active high |
| int_ack | input | 1 | Interrupt acknowledge, active high. Starts a new frame |
| tbl_we | input | 1 | Background table write enable |
| tbl_waddr | input | 8 | Background table write address |
| tbl_wdata | input | 14 | Background table write data |
| tile_word | output | 14 | Tile word for the current step |
| fetch_mode | output | 1 | High while steps load from the table |

## Verification
If the ring position is wrong, every replayed word is shifted. The first strobe after the error shows the wrong word, and the same offset repeats on every later line. If the index or the hold-off counter is wrong, the failure shows at a mode boundary. Either `fetch_mode` comes up one phase edge early or late, or the first word of a burst comes from the wrong table entry, or the index runs past 239. A partial burst of 19 words followed by a full replay makes a wrong position visible at its first strobe. That replay shows the slot left over from the previous row first, and then the new words in order.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
    localparam int WORD_W        = 14;
    localparam int RING_SLOTS    = 20;
    localparam int TABLE_ENTRIES = 240;
    localparam int FETCH_HOLDOFF = 9;
endpackage

// File: rtl/tlr_edge.sv
module tlr_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic tick
);
    typedef struct packed {
        logic sync;
        logic prev;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.sync = pin;
        d.prev = q.sync;
    end

    generate
        if (FALLING) begin : g_fall
            assign tick = q.prev & ~q.sync;
        end else begin : g_rise
            assign tick = ~q.prev & q.sync;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tlr_fetch_gate.sv
module tlr_fetch_gate #(
    parameter int HOLDOFF = tlr_pkg::FETCH_HOLDOFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_tick,
    input  logic shift_tick,
    input  logic ack,
    input  logic clr,
    output logic fetch
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] CNT_LIMIT = CW'(HOLDOFF);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fetch;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (clr || !ack) begin
            d.cnt   = '0;
            d.fetch = 1'b0;
        end else if (shift_tick) begin
            d.cnt = '0;
        end else if (phase_tick && q.cnt != CNT_LIMIT) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt + 1'b1 == CNT_LIMIT) d.fetch = 1'b1;
        end
    end

    assign fetch = q.fetch;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_LIMIT);
    a_r3_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        shift_tick |=> q.cnt == '0);
    a_r4_ack_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !q.fetch);
    a_r7_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q.fetch && q.cnt == '0);
endmodule

// File: rtl/tlr_bg_table.sv
module tlr_bg_table #(
    parameter int WIDTH   = tlr_pkg::WORD_W,
    parameter int ENTRIES = tlr_pkg::TABLE_ENTRIES,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < ENTRIES) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < ENTRIES) ? mem[raddr] : '0;
endmodule

// File: rtl/tlr_ring.sv
module tlr_ring #(
    parameter int WIDTH   = tlr_pkg::WORD_W,
    parameter int SLOTS   = tlr_pkg::RING_SLOTS,
    parameter int ENTRIES = tlr_pkg::TABLE_ENTRIES,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             fetch,
    input  logic             clr,
    input  logic [WIDTH-1:0] tbl_rdata,
    output logic [IW-1:0]    tbl_raddr,
    output logic [WIDTH-1:0] word
);
    localparam int PW = $clog2(SLOTS);
    localparam logic [PW-1:0] POS_LAST = PW'(SLOTS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(ENTRIES - 1);

    typedef struct packed {
        logic [SLOTS-1:0][WIDTH-1:0] ring;
        logic [PW-1:0]               pos;
        logic [IW-1:0]               idx;
        logic [WIDTH-1:0]            word;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.pos = '0;
            d.idx = '0;
        end else if (step) begin
            if (fetch) begin
                d.ring[q.pos] = tbl_rdata;
                d.word        = tbl_rdata;
                if (q.idx != IDX_LAST) d.idx = q.idx + 1'b1;
            end else begin
                d.word = q.ring[q.pos];
            end
            d.pos = (q.pos == POS_LAST) ? '0 : q.pos + 1'b1;
        end
    end

    assign tbl_raddr = q.idx;
    assign word      = q.word;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r2_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(q.word));
    a_r2_pos_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= POS_LAST);
    a_r6_replay_keeps_ring: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> $stable(q.ring));
    a_r7_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q.pos == '0 && q.idx == '0);
    a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_LAST);
endmodule

// File: rtl/tile_line_replay.sv
module tile_line_replay #(
    parameter int WIDTH   = tlr_pkg::WORD_W,
    parameter int SLOTS   = tlr_pkg::RING_SLOTS,
    parameter int ENTRIES = tlr_pkg::TABLE_ENTRIES,
    parameter int HOLDOFF = tlr_pkg::FETCH_HOLDOFF,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_clk,
    input  logic             shift_strobe,
    input  logic             bus_ack,
    input  logic             int_ack,
    input  logic             tbl_we,
    input  logic [AW-1:0]    tbl_waddr,
    input  logic [WIDTH-1:0] tbl_wdata,
    output logic [WIDTH-1:0] tile_word,
    output logic             fetch_mode
);
    logic             phase_tick, shift_tick;
    logic             ack_q, iack_q;
    logic [AW-1:0]    rd_addr;
    logic [WIDTH-1:0] rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            iack_q <= 1'b0;
        end else begin
            ack_q  <= bus_ack;
            iack_q <= int_ack;
        end
    end

    tlr_edge #(.FALLING(1'b0)) u_phase (
        .clk(clk), .rst_n(rst_n), .pin(phase_clk), .tick(phase_tick));

    tlr_edge #(.FALLING(1'b1)) u_shift (
        .clk(clk), .rst_n(rst_n), .pin(shift_strobe), .tick(shift_tick));

    tlr_fetch_gate #(.HOLDOFF(HOLDOFF)) u_gate (
        .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick),
        .shift_tick(shift_tick), .ack(ack_q), .clr(iack_q),
        .fetch(fetch_mode));

    tlr_bg_table #(.WIDTH(WIDTH), .ENTRIES(ENTRIES), .AW(AW)) u_table (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(rd_addr), .rdata(rd_data));

    tlr_ring #(.WIDTH(WIDTH), .SLOTS(SLOTS), .ENTRIES(ENTRIES), .IW(AW)) u_ring (
        .clk(clk), .rst_n(rst_n), .step(shift_tick), .fetch(fetch_mode),
        .clr(iack_q), .tbl_rdata(rd_data), .tbl_raddr(rd_addr),
        .word(tile_word));

    a_r5_fetch_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_mode |-> $past(ack_q));
endmodule

// File: tb/tb_tile_line_replay.sv
`timescale 1ns/1ps
module tb_tile_line_replay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_clk = 1'b0;
    logic        shift_strobe = 1'b0;
    logic        bus_ack = 1'b0;
    logic        int_ack = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_waddr = '0;
    logic [13:0] tbl_wdata = '0;
    logic [13:0] tile_word;
    logic        fetch_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tile_line_replay dut (
        .clk(clk), .rst_n(rst_n), .phase_clk(phase_clk),
        .shift_strobe(shift_strobe), .bus_ack(bus_ack), .int_ack(int_ack),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .tile_word(tile_word), .fetch_mode(fetch_mode));

    function automatic logic [13:0] tv(int i);
        return 14'((i * 173 + 11) & 16'h3fff);
    endfunction

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic phase_pulses(int n);
        for (int i = 0; i < n; i++) begin
            phase_clk = 1'b1; clks(3);
            phase_clk = 1'b0; clks(3);
        end
    endtask

    task automatic strobe();
        shift_strobe = 1'b1; clks(3);
        shift_strobe = 1'b0; clks(4);
    endtask

    task automatic frame_start();
        int_ack = 1'b1; clks(3);
        chk("R7 fetch off during int_ack", {13'd0, fetch_mode}, 14'd0);
        int_ack = 1'b0; clks(3);
    endtask

    task automatic enter_fetch();
        bus_ack = 1'b1; clks(3);
        phase_pulses(9);
    endtask

    task automatic leave_fetch();
        bus_ack = 1'b0; clks(4);
        chk("R4 fetch off after ack drop", {13'd0, fetch_mode}, 14'd0);
    endtask

    task automatic t_reset();
        clks(2); rst_n = 1'b1; clks(2);
        chk("R1 word after reset", tile_word, 14'd0);
        chk("R1 fetch after reset", {13'd0, fetch_mode}, 14'd0);
        for (int i = 0; i < 240; i++) begin
            tbl_we = 1'b1; tbl_waddr = 8'(i); tbl_wdata = tv(i); clks(1);
        end
        tbl_we = 1'b0; clks(1);
    endtask

    task automatic t_holdoff();
        bus_ack = 1'b1; clks(3);
        phase_pulses(5);
        strobe();
        chk("R1 ring slot empty after reset", tile_word, 14'd0);
        phase_pulses(8);
        chk("R3 no fetch after 8 edges", {13'd0, fetch_mode}, 14'd0);
        phase_pulses(1);
        chk("R3 fetch on 9th edge", {13'd0, fetch_mode}, 14'd1);
        leave_fetch();
    endtask

    task automatic t_full_row();
        frame_start();
        enter_fetch();
        chk("R3 fetch entered", {13'd0, fetch_mode}, 14'd1);
        for (int k = 0; k < 20; k++) begin
            strobe();
            chk("R5 fetched word", tile_word, tv(k));
        end
        leave_fetch();
        for (int line = 0; line < 3; line++) begin
            for (int k = 0; k < 20; k++) begin
                if (k == 5) begin
                    shift_strobe = 1'b1; clks(4);
                    chk("R2 rising edge no step", tile_word, tv(4));
                    shift_strobe = 1'b0; clks(4);
                end else begin
                    strobe();
                end
                chk("R6 replayed word", tile_word, tv(k));
            end
        end
    endtask

    task automatic t_partial();
        enter_fetch();
        for (int k = 0; k < 19; k++) begin
            strobe();
            chk("R9 partial burst word", tile_word, tv(20 + k));
        end
        leave_fetch();
        strobe();
        chk("R9 leftover slot first", tile_word, tv(19));
        for (int k = 0; k < 19; k++) begin
            strobe();
            chk("R9 replay after partial", tile_word, tv(20 + k));
        end
    endtask

    task automatic t_saturate();
        frame_start();
        enter_fetch();
        for (int k = 0; k < 245; k++) begin
            strobe();
            if (k < 3 || k > 236)
                chk("R8 index saturates", tile_word, tv(k > 239 ? 239 : k));
        end
        leave_fetch();
        frame_start();
        enter_fetch();
        strobe();
        chk("R7 index back to 0", tile_word, tv(0));
        leave_fetch();
    endtask

    initial begin
        t_reset();
        t_holdoff();
        t_full_row();
        t_partial();
        t_saturate();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule